// File: doc/BRIEF.md
# DDR2 Bring-up and Refresh Sequencer

This block finishes the power-up of a DDR2 SDRAM from the controller side and then keeps the device refreshed. When `start_i` is pulsed while the block is idle, it drives a fixed series of items onto a simple command bus. Each item is a command code, a two-bit bank select and a system address. Every item stays on the bus until the bus raises `cmd_ack_i`.

The programming order is fixed. First comes a mode-register load, which sets CAS latency and burst length and releases DLL reset. Next come two extended-mode (EMRS1) loads: one puts off-chip-driver calibration at its default setting and the other leaves calibration. Last comes a switch to normal operation. The device only accepts a mode change when a memory access follows it, so each of these four commands is followed by an access item. One more plain write access closes the series. The bank bits map to system address bits 23:22, so bank 1 sits 0x400000 above the memory base.

After the last access the block raises `done_o` and enables a refresh pacer. The pacer raises `ref_req_o` once every `ref_count_i` clock cycles. At 133 MHz, for example, 2079 cycles gives 15.625 µs and 1039 cycles gives 7.81 µs. Each request stays raised until `ref_ack_i` is seen.

Top module: `ddr2_bringup_seq`

States of the sequencer, in the order the transitions visit them: `ST_IDLE` moves to `ST_MRS` on start. Each following state moves to the next one when the bus acknowledges: `ST_MRS`, `ST_MRS_ACC`, `ST_OCD_DFLT`, `ST_OCD_DFLT_ACC`, `ST_OCD_EXIT`, `ST_OCD_EXIT_ACC`, `ST_NORMAL`, `ST_NORMAL_ACC`, `ST_FINAL_WR`, then `ST_DONE`. `ST_DONE` is left only by reset.

## Requirements
- R1: Synchronous active-low reset leaves `cmd_o` = 0 (NOP), `ba_o` = 0, `addr_o` = 0, `done_o` = 0 and `ref_req_o` = 0.
- R2: After a start pulse in idle, the bus shows exactly nine items in this order, with command codes 1 = mode set, 2 = EMRS1 calibration default, 3 = EMRS1 calibration exit, 4 = go normal, 5 = access: 1, 5, 2, 5, 3, 5, 4, 5, 5. The first item appears one cycle after the start edge.
- R3: Mode set, go normal, the access after each of them and the closing access use bank 00. Both EMRS1 items and the access after each of them use bank 01.
- R4: Whenever `cmd_o` is not NOP, `addr_o` equals MEM_BASE plus the bank value shifted to bit BANK_LSB (0x20000000 for bank 0 and 0x20400000 for bank 1 with the defaults). During NOP, `addr_o` is 0.
- R5: An item holds `cmd_o`, `ba_o` and `addr_o` steady until `cmd_ack_i` is sampled high. The next item appears in the cycle after that edge. `cmd_ack_i` has no effect while `cmd_o` is NOP.
- R6: `start_i` is ignored while a series is running and after `done_o` is set.
- R7: `done_o` rises in the cycle after the closing access is acknowledged. It then stays high with `cmd_o` at NOP until reset.
- R8: With `done_o` high and `ref_count_i` = N > 0, the first `ref_req_o` is seen N cycles after `done_o` is first seen, and further expiries follow every N cycles. A changed N takes effect from the current interval.
- R9: `ref_req_o` stays high until `ref_ack_i` is sampled and falls in the next cycle. If an acknowledge falls on an expiry edge, the request stays high.
- R10: `ref_req_o` stays low while `done_o` is low or `ref_count_i` is 0. Setting the count to 0 also drops a pending request.
- R11: Reset in the middle of a series returns the bus to NOP with `done_o` low. A new start then runs the whole series from the mode set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin the bring-up series (idle only) |
| cmd_ack_i | input | 1 | Bus accepted the current item |
| cmd_o | output | 3 | Command code (0 NOP, 1 mode set, 2 EMRS1 cal default, 3 EMRS1 cal exit, 4 go normal, 5 access) |
| ba_o | output | 2 | Bank select for the current item |
| addr_o | output | ADDR_W | System address of the current item |
| done_o | output | 1 | Device initialized |
| ref_count_i | input | CNT_W | Refresh interval in clock cycles, 0 disables |
| ref_req_o | output | 1 | Pending refresh request |
| ref_ack_i | input | 1 | Refresh request taken |

## Verification
Every bus item comes straight from the state register. It is therefore visible one cycle after the start or acknowledge edge that caused it, and `done_o` appears one cycle after the last acknowledge. The scoreboard monitor samples on the falling edge, compares each new item against the queue the driver filled, and answers with an acknowledge after 0, 1 or 2 extra cycles. Refresh requests are due exactly N falling-edge samples after `done_o` is first seen and every N samples after that. Acknowledges are placed on chosen sample numbers, so that one clears a request between expiries and another collides with an expiry edge. Each result is then read on the first sample where the requirements say it must have changed.

// File: rtl/ddr2_seq_pkg.sv
package ddr2_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP          = 3'd0,
        CMD_MODE_SET     = 3'd1,
        CMD_EXT_CAL_DFLT = 3'd2,
        CMD_EXT_CAL_EXIT = 3'd3,
        CMD_GO_NORMAL    = 3'd4,
        CMD_ACCESS       = 3'd5
    } bus_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MRS,
        ST_MRS_ACC,
        ST_OCD_DFLT,
        ST_OCD_DFLT_ACC,
        ST_OCD_EXIT,
        ST_OCD_EXIT_ACC,
        ST_NORMAL,
        ST_NORMAL_ACC,
        ST_FINAL_WR,
        ST_DONE
    } seq_state_e;

    localparam logic [1:0] BANK_MODE = 2'b00;
    localparam logic [1:0] BANK_EXT1 = 2'b01;

endpackage

// File: rtl/ddr2_init_fsm.sv
module ddr2_init_fsm
    import ddr2_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     cmd_ack_i,
    output bus_cmd_e cmd_o,
    output logic [1:0] ba_o,
    output logic     done_o
);

    seq_state_e state_q;
    seq_state_e state_d;

    // Next-state selection: every issuing state waits for the bus acknowledge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:         if (start_i)   state_d = ST_MRS;
            ST_MRS:          if (cmd_ack_i) state_d = ST_MRS_ACC;
            ST_MRS_ACC:      if (cmd_ack_i) state_d = ST_OCD_DFLT;
            ST_OCD_DFLT:     if (cmd_ack_i) state_d = ST_OCD_DFLT_ACC;
            ST_OCD_DFLT_ACC: if (cmd_ack_i) state_d = ST_OCD_EXIT;
            ST_OCD_EXIT:     if (cmd_ack_i) state_d = ST_OCD_EXIT_ACC;
            ST_OCD_EXIT_ACC: if (cmd_ack_i) state_d = ST_NORMAL;
            ST_NORMAL:       if (cmd_ack_i) state_d = ST_NORMAL_ACC;
            ST_NORMAL_ACC:   if (cmd_ack_i) state_d = ST_FINAL_WR;
            ST_FINAL_WR:     if (cmd_ack_i) state_d = ST_DONE;
            ST_DONE:                        state_d = ST_DONE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from the registered state
    always_comb begin
        cmd_o  = CMD_NOP;
        ba_o   = BANK_MODE;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:         cmd_o = CMD_NOP;
            ST_MRS:          cmd_o = CMD_MODE_SET;
            ST_MRS_ACC:      cmd_o = CMD_ACCESS;
            ST_OCD_DFLT: begin
                cmd_o = CMD_EXT_CAL_DFLT;
                ba_o  = BANK_EXT1;
            end
            ST_OCD_DFLT_ACC: begin
                cmd_o = CMD_ACCESS;
                ba_o  = BANK_EXT1;
            end
            ST_OCD_EXIT: begin
                cmd_o = CMD_EXT_CAL_EXIT;
                ba_o  = BANK_EXT1;
            end
            ST_OCD_EXIT_ACC: begin
                cmd_o = CMD_ACCESS;
                ba_o  = BANK_EXT1;
            end
            ST_NORMAL:       cmd_o = CMD_GO_NORMAL;
            ST_NORMAL_ACC:   cmd_o = CMD_ACCESS;
            ST_FINAL_WR:     cmd_o = CMD_ACCESS;
            ST_DONE:         done_o = 1'b1;
            default:         cmd_o = CMD_NOP;
        endcase
    end

    AST_CMD_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != CMD_NOP && !cmd_ack_i) |=> ($stable(cmd_o) && $stable(ba_o))); // R5
    AST_FIRST_ITEM_MODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (cmd_o == CMD_MODE_SET)); // R2
    AST_EXT_USES_BANK1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_EXT_CAL_DFLT || cmd_o == CMD_EXT_CAL_EXIT) |-> (ba_o == 2'b01)); // R3
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o); // R7
    AST_DONE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cmd_o == CMD_NOP)); // R7

endmodule

// File: rtl/ddr2_addr_map.sv
module ddr2_addr_map #(
    parameter int ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] MEM_BASE = 32'h2000_0000,
    parameter int BANK_LSB = 22
) (
    input  logic              valid_i,
    input  logic [1:0]        ba_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int PAD_W = ADDR_W - 2;

    logic [ADDR_W-1:0] bank_field;

    always_comb begin
        bank_field = {{PAD_W{1'b0}}, ba_i} << BANK_LSB;
        addr_o     = valid_i ? (MEM_BASE | bank_field) : '0;
    end

endmodule

// File: rtl/ddr2_refresh_timer.sv
module ddr2_refresh_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             ack_i,
    output logic             req_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] elapsed_q;
    logic             pend_q;
    logic             active;
    logic             expire;

    always_comb begin
        active = en_i && (count_i != '0);
        expire = active && (elapsed_q >= (count_i - ONE));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= '0;
            pend_q    <= 1'b0;
        end else if (!active) begin
            elapsed_q <= '0;
            pend_q    <= 1'b0;
        end else begin
            elapsed_q <= expire ? '0 : elapsed_q + ONE;
            if (expire)     pend_q <= 1'b1;
            else if (ack_i) pend_q <= 1'b0;
        end
    end

    assign req_o = pend_q;

    AST_REQ_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i && en_i && count_i != '0) |=> req_o); // R9
    AST_REQ_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || count_i == '0) |=> !req_o); // R10

endmodule

// File: rtl/ddr2_bringup_seq.sv
module ddr2_bringup_seq
    import ddr2_seq_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] MEM_BASE = 32'h2000_0000,
    parameter int BANK_LSB = 22,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmd_ack_i,
    output logic [2:0]        cmd_o,
    output logic [1:0]        ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o,
    input  logic [CNT_W-1:0]  ref_count_i,
    output logic              ref_req_o,
    input  logic              ref_ack_i
);

    bus_cmd_e   fsm_cmd;
    logic [1:0] fsm_ba;
    logic       fsm_done;

    ddr2_init_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .cmd_ack_i (cmd_ack_i),
        .cmd_o     (fsm_cmd),
        .ba_o      (fsm_ba),
        .done_o    (fsm_done)
    );

    ddr2_addr_map #(
        .ADDR_W   (ADDR_W),
        .MEM_BASE (MEM_BASE),
        .BANK_LSB (BANK_LSB)
    ) u_addr (
        .valid_i (fsm_cmd != CMD_NOP),
        .ba_i    (fsm_ba),
        .addr_o  (addr_o)
    );

    ddr2_refresh_timer #(
        .CNT_W (CNT_W)
    ) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (fsm_done),
        .count_i (ref_count_i),
        .ack_i   (ref_ack_i),
        .req_o   (ref_req_o)
    );

    assign cmd_o  = fsm_cmd;
    assign ba_o   = fsm_ba;
    assign done_o = fsm_done;

    AST_NOP_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd0) |-> (addr_o == '0)); // R4

endmodule

// File: tb/ddr2_bringup_seq_tb.sv
module ddr2_bringup_seq_tb;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start_i;
    logic              cmd_ack_i;
    logic [2:0]        cmd_o;
    logic [1:0]        ba_o;
    logic [ADDR_W-1:0] addr_o;
    logic              done_o;
    logic [CNT_W-1:0]  ref_count_i;
    logic              ref_req_o;
    logic              ref_ack_i;

    always #2 clk = ~clk;

    ddr2_bringup_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cmd_ack_i   (cmd_ack_i),
        .cmd_o       (cmd_o),
        .ba_o        (ba_o),
        .addr_o      (addr_o),
        .done_o      (done_o),
        .ref_count_i (ref_count_i),
        .ref_req_o   (ref_req_o),
        .ref_ack_i   (ref_ack_i)
    );

    typedef struct packed {
        logic [2:0]  cmd;
        logic [1:0]  ba;
        logic [31:0] addr;
    } item_t;

    item_t exp_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    int    items_seen = 0;
    logic  mon_en = 1'b0;
    logic  mon_ack = 1'b0;
    logic  force_ack = 1'b0;
    logic  seen = 1'b0;
    int    wait_cnt = 0;

    assign cmd_ack_i = mon_ack | force_ack;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_item(input logic [2:0] c, input logic [1:0] b);
        item_t it;
        it.cmd  = c;
        it.ba   = b;
        it.addr = 32'h2000_0000 | (32'(b) << 22);
        exp_q.push_back(it);
    endtask

    // Driver: expected bus items of one full series
    task automatic push_sequence();
        push_item(3'd1, 2'b00); push_item(3'd5, 2'b00);
        push_item(3'd2, 2'b01); push_item(3'd5, 2'b01);
        push_item(3'd3, 2'b01); push_item(3'd5, 2'b01);
        push_item(3'd4, 2'b00); push_item(3'd5, 2'b00);
        push_item(3'd5, 2'b00);
    endtask

    task automatic summary_and_exit();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Monitor: pops and compares each new item, acknowledges after 0..2 cycles
    initial begin
        forever begin
            @(negedge clk);
            if (!mon_en) begin
                mon_ack = 1'b0;
                seen    = 1'b0;
            end else if (cmd_o != 3'd0) begin
                if (!seen) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2", "unexpected item", 32'(cmd_o), 32'd0);
                    end else begin
                        item_t e;
                        e = exp_q.pop_front();
                        check(cmd_o == e.cmd, "R2", "command order", 32'(cmd_o), 32'(e.cmd));
                        check(ba_o == e.ba, "R3", "bank select", 32'(ba_o), 32'(e.ba));
                        check(addr_o == e.addr, "R4", "address", addr_o, e.addr);
                    end
                    items_seen++;
                    seen     = 1'b1;
                    wait_cnt = 0;
                end
                if (wait_cnt >= (items_seen % 3)) begin
                    mon_ack = 1'b1;
                    seen    = 1'b0;
                end else begin
                    mon_ack = 1'b0;
                    wait_cnt++;
                end
            end else begin
                mon_ack = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary_and_exit();
    end

    task automatic run_series(input int pulse_at);
        int t;
        exp_q.delete();
        push_sequence();
        items_seen = 0;
        mon_en = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        t = 0;
        while (!done_o && t < 500) begin
            @(negedge clk);
            t++;
            start_i = (t == pulse_at);    // R6: start while busy
            if (ref_req_o) check(1'b0, "R10", "request before done", 1, 0);
        end
        start_i = 1'b0;
        check(done_o == 1'b1, "R7", "done after series", 32'(done_o), 1);
        check(items_seen == 9, "R2", "item count", 32'(items_seen), 9);
        check(exp_q.size() == 0, "R6", "no restart while busy", 32'(exp_q.size()), 0);
        check(ref_req_o == 1'b0, "R8", "no request at done", 32'(ref_req_o), 0);
    endtask

    task automatic measure_first(input int n_exp);
        int n;
        n = 0;
        while (!ref_req_o && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(n == n_exp, "R8", "cycles done to first request", 32'(n), 32'(n_exp));
    endtask

    initial begin
        rst_n = 1'b0;
        start_i = 1'b0;
        ref_ack_i = 1'b0;
        ref_count_i = 16'd5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_o == 3'd0, "R1", "reset cmd", 32'(cmd_o), 0);
        check(ba_o == 2'd0 && addr_o == '0, "R1", "reset bank/addr", addr_o, 0);
        check(done_o == 1'b0 && ref_req_o == 1'b0, "R1", "reset flags",
              32'({done_o, ref_req_o}), 0);

        // R5: acknowledge while idle has no effect
        force_ack = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(cmd_o == 3'd0 && done_o == 1'b0, "R5", "ack in idle", 32'(cmd_o), 0);
        end
        force_ack = 1'b0;

        run_series(10);
        measure_first(5);

        // R9: request held while not acknowledged (samples S0+6..S0+13)
        repeat (8) begin
            @(negedge clk);
            check(ref_req_o == 1'b1, "R9", "request held", 32'(ref_req_o), 1);
        end
        ref_ack_i = 1'b1;
        @(negedge clk);
        ref_ack_i = 1'b0;
        check(ref_req_o == 1'b0, "R9", "cleared by ack", 32'(ref_req_o), 0);
        @(negedge clk);
        check(ref_req_o == 1'b1, "R8", "next expiry in period", 32'(ref_req_o), 1);
        ref_ack_i = 1'b1;
        @(negedge clk);
        ref_ack_i = 1'b0;
        check(ref_req_o == 1'b0, "R9", "cleared again", 32'(ref_req_o), 0);
        repeat (3) @(negedge clk);
        ref_ack_i = 1'b1;
        @(negedge clk);
        check(ref_req_o == 1'b1, "R9", "expiry wins over ack", 32'(ref_req_o), 1);
        @(negedge clk);
        check(ref_req_o == 1'b0, "R9", "ack after collision", 32'(ref_req_o), 0);
        ref_ack_i = 1'b0;

        // R6: start after done ignored
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) begin
            @(negedge clk);
            check(cmd_o == 3'd0 && done_o == 1'b1, "R6", "start after done", 32'(cmd_o), 0);
        end

        // R8: new interval of 12
        ref_count_i = 16'd12;
        ref_ack_i = 1'b1;
        repeat (2) @(negedge clk);
        ref_ack_i = 1'b0;
        begin
            int n;
            n = 0;
            while (!ref_req_o && n < 100) begin
                @(negedge clk);
                n++;
            end
            ref_ack_i = 1'b1;
            @(negedge clk);
            ref_ack_i = 1'b0;
            n = 1;
            while (!ref_req_o && n < 100) begin
                @(negedge clk);
                n++;
            end
            check(n == 12, "R8", "period after count change", 32'(n), 12);
        end

        // R10: zero count silences refresh
        ref_count_i = 16'd0;
        repeat (30) begin
            @(negedge clk);
            check(ref_req_o == 1'b0, "R10", "count zero", 32'(ref_req_o), 0);
        end

        // R11: reset in mid-series
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ref_count_i = 16'd7;
        exp_q.delete();
        push_sequence();
        items_seen = 0;
        mon_en = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (items_seen < 3) @(negedge clk);
        rst_n = 1'b0;
        mon_en = 1'b0;
        exp_q.delete();
        @(negedge clk);
        check(cmd_o == 3'd0 && done_o == 1'b0, "R11", "mid-series reset", 32'(cmd_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_o == 3'd0, "R11", "idle after reset", 32'(cmd_o), 0);
        run_series(0);
        measure_first(7);

        summary_and_exit();
    end

endmodule